// File: doc/BRIEF.md
# Snapshot Read Buffer for a Shared Message RAM

This block sits between a host request port and a main message RAM that a serial-bus DMA engine also fills. Message RAM is organised as subaddresses of 32 words each. When the host starts reading a message, the block copies the whole message into a private 32-word buffer. The host then reads that buffer at its own pace. Every word it gets comes from one consistent copy, even if the serial bus rewrites the message while the host is still reading.

The host reads a message from its highest index down to index 0. The first read, at index k, names the message length: words 0 to k are copied in one burst. Reading index 0 closes the sequence, and the next read of that message triggers a fresh copy. While a burst runs, the host waits. A burst that has started always finishes. A burst that is still pending waits for the serial DMA to go idle. Subaddresses 0 and 31 are never buffered. Two enable bits control the block: the read enable switches buffering on or off, and the write enable is passed on to the separate write path. Both are set by writes to a small configuration window.

Requests use a valid/ready channel. The host holds a request, with its address, write flag and data, stable until `host_req_ready` accepts it. `host_req_ready` is low while the block is busy, and being busy is how the host is locked out. Read results come back on a second valid/ready channel. A result stays on the port until `host_rsp_ready` takes it, and no new request is accepted before that. Writes produce no result.

Top module: `btl_read_buf`

## Requirements
- R1: After reset, read buffering and write buffering are both enabled (`wr_buf_en` = 1). No snapshot is held, `host_req_ready` = 1, `host_rsp_valid` = 0 and `mem_en` = 0.
- R2: Host address layout: bit 10 selects the configuration window, bits 9:5 are the subaddress and bits 4:0 are the word index. With buffering on, a first read of subaddress s (1 to 30) at index k copies words 0..k of s in ascending order, one main-RAM read every CYC_PER_WORD cycles. The result is word k and appears on the port (k+1)·CYC_PER_WORD+2 cycles after acceptance. `host_req_ready` stays low until then.
- R3: While a snapshot of s is held, a read of s at an index at or below k is answered from the buffer one cycle after acceptance. It makes no main-RAM access and returns the copied value even if RAM has changed since the copy.
- R4: A read of index 0 closes the snapshot, so the next read of that subaddress copies again and sees current RAM.
- R5: If `dma_busy` rises during a burst, the burst completes with unchanged timing. After that, no new main-RAM access starts until `dma_busy` falls, but reads that hit the snapshot are still served.
- R6: If `dma_busy` is high when a burst would start, no main-RAM access is made and the host waits. The burst begins only after `dma_busy` is low.
- R7: Reads of subaddress 0 or 31 always go to main RAM: one access each, result 3 cycles after acceptance when the RAM is free.
- R8: A host write to configuration offset 402h..405h sets the enables from (offset − 402h): bit 1 is the read enable and bit 0 is the write enable (`wr_buf_en`). Writes to other configuration offsets change nothing.
- R9: With read buffering off, reads go straight to main RAM, and any held snapshot is dropped.
- R10: Host writes to the RAM region wait for `dma_busy` to be low, write main RAM once, produce no result and leave the snapshot untouched.
- R11: `host_rsp_valid`, once high, stays high with stable `host_rsp_data` until `host_rsp_ready`. `host_req_ready` is low meanwhile.
- R12: A buffered read that misses the snapshot, because it names another subaddress or an index above k, drops the snapshot and starts a new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req_valid | input | 1 | Host request present |
| host_req_ready | output | 1 | Request accepted this cycle; low means the host waits |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_addr | input | 11 | {config select, subaddress, word index} |
| host_req_wdata | input | 16 | Write data |
| host_rsp_valid | output | 1 | Read result present |
| host_rsp_ready | input | 1 | Host takes the read result |
| host_rsp_data | output | 16 | Read result |
| mem_en | output | 1 | Main-RAM access this cycle |
| mem_we | output | 1 | Main-RAM access is a write |
| mem_addr | output | 10 | {subaddress, word index} |
| mem_wdata | output | 16 | Main-RAM write data |
| mem_rdata | input | 16 | Main-RAM read data, one cycle after `mem_en` |
| dma_busy | input | 1 | Serial-bus DMA owns main RAM |
| wr_buf_en | output | 1 | Write-buffer enable for the write path |

## Verification
The checker assumes the following about the block's inputs. `mem_rdata` is valid exactly one cycle after a read access. The host holds each request stable until it is accepted. CYC_PER_WORD is at least 3. The serial DMA never rewrites the subaddress that is currently being copied. The bench RAM model answers with one cycle of latency, and the bench drives requests only from negative edges. Each DMA collision in the bench writes a different subaddress from the one being copied, or lands before or after the copy. This keeps the snapshot values that the bench predicts well defined.

// File: rtl/btl_pkg.sv
package btl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_BURST,
    ST_PASS,
    ST_PDATA,
    ST_RESP
  } btl_state_e;

  localparam int CFG_FIRST = 2;
  localparam int CFG_LAST  = 5;
endpackage

// File: rtl/btl_cfg.sv
module btl_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_bits,
  output logic       rd_en,
  output logic       wr_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en <= 1'b1;
      wr_en <= 1'b1;
    end else if (cfg_we) begin
      rd_en <= cfg_bits[1];
      wr_en <= cfg_bits[0];
    end
  end
endmodule

// File: rtl/btl_buf.sv
module btl_buf #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] words_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words_q[waddr] <= wdata;
  end

  assign rdata = words_q[raddr];
endmodule

// File: rtl/btl_ctrl.sv
module btl_ctrl
  import btl_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int SA_W         = 5,
  parameter int IDX_W        = 5,
  parameter int CYC_PER_WORD = 50
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [SA_W+IDX_W:0]     req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [DATA_W-1:0]       rsp_data,
  output logic                    mem_en,
  output logic                    mem_we,
  output logic [SA_W+IDX_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic [DATA_W-1:0]       mem_rdata,
  input  logic                    dma_busy,
  input  logic                    rd_en,
  output logic                    cfg_we,
  output logic [1:0]              cfg_bits,
  output logic                    buf_we,
  output logic [IDX_W-1:0]        buf_waddr,
  output logic [DATA_W-1:0]       buf_wdata,
  output logic [IDX_W-1:0]        buf_raddr,
  input  logic [DATA_W-1:0]       buf_rdata,
  output logic                    burst_act
);
  localparam int MAW   = SA_W + IDX_W;
  localparam int ADDR_W = MAW + 1;
  localparam int LOW_W = ADDR_W - 1;
  localparam int TW    = $clog2(CYC_PER_WORD + 1);
  localparam logic [TW-1:0] T_LAST = TW'(CYC_PER_WORD - 1);

  btl_state_e state_q;

  logic              seq_active_q;
  logic [SA_W-1:0]   seq_sa_q;
  logic [IDX_W-1:0]  seq_top_q;
  logic [IDX_W-1:0]  word_q;
  logic [TW-1:0]     tmr_q;
  logic              pend_q;
  logic [IDX_W-1:0]  pend_idx_q;
  logic [MAW-1:0]    op_addr_q;
  logic              op_we_q;
  logic [DATA_W-1:0] op_wdata_q;
  logic [DATA_W-1:0] rsp_q;

  // request decode
  logic              is_cfg, cfg_hit, sa_buffered, snap_hit, accept;
  logic [SA_W-1:0]   req_sa;
  logic [IDX_W-1:0]  req_idx;
  logic [LOW_W-1:0]  low;

  assign is_cfg      = req_addr[ADDR_W-1];
  assign req_sa      = req_addr[MAW-1:IDX_W];
  assign req_idx     = req_addr[IDX_W-1:0];
  assign low         = req_addr[LOW_W-1:0];
  assign cfg_hit     = (low >= LOW_W'(CFG_FIRST)) && (low <= LOW_W'(CFG_LAST));
  assign sa_buffered = (req_sa != '0) && (req_sa != {SA_W{1'b1}});
  assign snap_hit    = seq_active_q && (req_sa == seq_sa_q) && (req_idx <= seq_top_q);
  assign req_ready   = (state_q == ST_IDLE);
  assign accept      = req_valid && req_ready;

  assign cfg_we   = accept && is_cfg && req_write && cfg_hit;
  assign cfg_bits = low[1:0] + 2'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      seq_active_q <= 1'b0;
      seq_sa_q     <= '0;
      seq_top_q    <= '0;
      word_q       <= '0;
      tmr_q        <= '0;
      pend_q       <= 1'b0;
      pend_idx_q   <= '0;
      op_addr_q    <= '0;
      op_we_q      <= 1'b0;
      op_wdata_q   <= '0;
      rsp_q        <= '0;
    end else begin
      pend_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (is_cfg) begin
              if (!req_write) begin
                rsp_q   <= '0;
                state_q <= ST_RESP;
              end
            end else if (req_write) begin
              op_addr_q  <= req_addr[MAW-1:0];
              op_we_q    <= 1'b1;
              op_wdata_q <= req_wdata;
              state_q    <= ST_PASS;
            end else if (rd_en && sa_buffered) begin
              if (snap_hit) begin
                rsp_q <= buf_rdata;
                if (req_idx == '0) seq_active_q <= 1'b0;
                state_q <= ST_RESP;
              end else begin
                seq_active_q <= 1'b0;
                seq_sa_q     <= req_sa;
                seq_top_q    <= req_idx;
                state_q      <= ST_WAIT;
              end
            end else begin
              op_addr_q <= req_addr[MAW-1:0];
              op_we_q   <= 1'b0;
              state_q   <= ST_PASS;
            end
          end
        end
        ST_WAIT: begin
          if (!dma_busy) begin
            word_q  <= '0;
            tmr_q   <= '0;
            state_q <= ST_BURST;
          end
        end
        ST_BURST: begin
          if (tmr_q == '0) begin
            pend_q     <= 1'b1;
            pend_idx_q <= word_q;
          end
          if (tmr_q == T_LAST) begin
            tmr_q <= '0;
            if (word_q == seq_top_q) begin
              rsp_q        <= buf_rdata;
              seq_active_q <= (seq_top_q != '0);
              state_q      <= ST_RESP;
            end else begin
              word_q <= word_q + 1'b1;
            end
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_PASS: begin
          if (!dma_busy) state_q <= op_we_q ? ST_IDLE : ST_PDATA;
        end
        ST_PDATA: begin
          rsp_q   <= mem_rdata;
          state_q <= ST_RESP;
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (!rd_en) seq_active_q <= 1'b0;
    end
  end

  assign burst_act = (state_q == ST_BURST);
  assign mem_en    = (burst_act && tmr_q == '0) || (state_q == ST_PASS && !dma_busy);
  assign mem_we    = (state_q == ST_PASS) && op_we_q && !dma_busy;
  assign mem_addr  = burst_act ? {seq_sa_q, word_q} : op_addr_q;
  assign mem_wdata = op_wdata_q;

  assign buf_we    = pend_q;
  assign buf_waddr = pend_idx_q;
  assign buf_wdata = mem_rdata;
  assign buf_raddr = burst_act ? seq_top_q : req_idx;

  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_data  = rsp_q;
endmodule

// File: rtl/btl_read_buf.sv
module btl_read_buf #(
  parameter int DATA_W       = 16,
  parameter int SA_W         = 5,
  parameter int IDX_W        = 5,
  parameter int CYC_PER_WORD = 50
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_req_valid,
  output logic                   host_req_ready,
  input  logic                   host_req_write,
  input  logic [SA_W+IDX_W:0]    host_req_addr,
  input  logic [DATA_W-1:0]      host_req_wdata,
  output logic                   host_rsp_valid,
  input  logic                   host_rsp_ready,
  output logic [DATA_W-1:0]      host_rsp_data,
  output logic                   mem_en,
  output logic                   mem_we,
  output logic [SA_W+IDX_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic [DATA_W-1:0]      mem_rdata,
  input  logic                   dma_busy,
  output logic                   wr_buf_en
);
  logic              rd_en, cfg_we, buf_we, burst_act;
  logic [1:0]        cfg_bits;
  logic [IDX_W-1:0]  buf_waddr, buf_raddr;
  logic [DATA_W-1:0] buf_wdata, buf_rdata;

  btl_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bits(cfg_bits),
    .rd_en(rd_en), .wr_en(wr_buf_en)
  );

  btl_buf #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  btl_ctrl #(
    .DATA_W(DATA_W), .SA_W(SA_W), .IDX_W(IDX_W), .CYC_PER_WORD(CYC_PER_WORD)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(host_req_valid), .req_ready(host_req_ready),
    .req_write(host_req_write), .req_addr(host_req_addr), .req_wdata(host_req_wdata),
    .rsp_valid(host_rsp_valid), .rsp_ready(host_rsp_ready), .rsp_data(host_rsp_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dma_busy(dma_busy), .rd_en(rd_en),
    .cfg_we(cfg_we), .cfg_bits(cfg_bits),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata), .burst_act(burst_act)
  );
endmodule

// File: rtl/btl_read_buf_chk.sv
module btl_read_buf_chk #(
  parameter int DATA_W       = 16,
  parameter int SA_W         = 5,
  parameter int IDX_W        = 5,
  parameter int CYC_PER_WORD = 50
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  host_req_ready,
  input logic                  host_rsp_valid,
  input logic                  host_rsp_ready,
  input logic [DATA_W-1:0]     host_rsp_data,
  input logic                  mem_en,
  input logic                  mem_we,
  input logic [SA_W+IDX_W-1:0] mem_addr,
  input logic                  dma_busy,
  input logic                  burst_act
);
  localparam int GW = $clog2(CYC_PER_WORD + 1);

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (!burst_act) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (mem_en) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != {GW{1'b1}}) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assert_burst_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    burst_act && mem_en && seen_q |-> gap_q == GW'(CYC_PER_WORD - 1));

  assert_dma_lockout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && dma_busy |-> burst_act);

  assert_burst_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_act) |-> $past(!dma_busy));

  assert_unbuffered_sa_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_act && mem_en |-> mem_addr[SA_W+IDX_W-1:IDX_W] != '0
                            && mem_addr[SA_W+IDX_W-1:IDX_W] != {SA_W{1'b1}});

  assert_burst_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    burst_act |-> !mem_we);

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid && !host_rsp_ready |=> host_rsp_valid && $stable(host_rsp_data));

  assert_no_accept_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid |-> !host_req_ready);
endmodule

bind btl_read_buf btl_read_buf_chk #(
  .DATA_W(DATA_W), .SA_W(SA_W), .IDX_W(IDX_W), .CYC_PER_WORD(CYC_PER_WORD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_req_ready(host_req_ready),
  .host_rsp_valid(host_rsp_valid), .host_rsp_ready(host_rsp_ready),
  .host_rsp_data(host_rsp_data), .mem_en(mem_en), .mem_we(mem_we),
  .mem_addr(mem_addr), .dma_busy(dma_busy), .burst_act(burst_act)
);

// File: tb/btl_read_buf_bench.sv
module btl_read_buf_bench;
  localparam int CPW = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [10:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, mem_en, mem_we, wr_buf_en;
  logic [15:0] rsp_data, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [9:0]  mem_addr;
  logic        dma_busy = 1'b0;

  logic        ram_init = 1'b0, dma_we = 1'b0;
  logic [9:0]  dma_addr = '0;
  logic [15:0] dma_wdata = '0;
  logic [15:0] ram [1024];
  int          mem_rd_cnt = 0;
  int          total = 0, bad = 0;
  logic [15:0] rd_data;
  int          rd_lat;

  always #2.5 clk = ~clk;

  btl_read_buf #(.CYC_PER_WORD(CPW)) u_btl_read_buf (
    .clk(clk), .rst_n(rst_n),
    .host_req_valid(req_valid), .host_req_ready(req_ready),
    .host_req_write(req_write), .host_req_addr(req_addr), .host_req_wdata(req_wdata),
    .host_rsp_valid(rsp_valid), .host_rsp_ready(rsp_ready), .host_rsp_data(rsp_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dma_busy(dma_busy), .wr_buf_en(wr_buf_en)
  );

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 97) ^ 16'h5A3C);
  endfunction

  function automatic logic [10:0] ma(input int sa, input int idx);
    return {1'b0, 5'(sa), 5'(idx)};
  endfunction

  function automatic int ra(input int sa, input int idx);
    return sa * 32 + idx;
  endfunction

  always @(posedge clk) begin
    if (ram_init) begin
      for (int i = 0; i < 1024; i++) ram[i] <= pat(i);
    end else begin
      if (mem_en && mem_we) ram[mem_addr] <= mem_wdata;
      if (mem_en && !mem_we) mem_rdata <= ram[mem_addr];
      if (dma_we) ram[dma_addr] <= dma_wdata;
    end
    if (rst_n && mem_en && !mem_we) mem_rd_cnt <= mem_rd_cnt + 1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic host_read(input logic [10:0] a, input int hold);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd_lat = 1;
    while (!rsp_valid) begin @(negedge clk); rd_lat++; end
    rd_data = rsp_data;
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk("R11", "rsp_valid held", int'(rsp_valid), 1);
      chk("R11", "rsp_data stable", int'(rsp_data), int'(rd_data));
      chk("R11", "req_ready low while pending", int'(req_ready), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic host_write(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic dma_write(input int a, input logic [15:0] d);
    @(negedge clk);
    dma_we = 1'b1; dma_addr = 10'(a); dma_wdata = d;
    @(negedge clk);
    dma_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "req_ready", int'(req_ready), 1);
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
    chk("R1", "wr_buf_en", int'(wr_buf_en), 1);
    chk("R1", "mem_en", int'(mem_en), 0);
  endtask

  task automatic t_burst;
    int c0;
    c0 = mem_rd_cnt;
    host_read(ma(5, 3), 0);
    chk("R1", "read buffering on after reset: burst latency", rd_lat, 4 * CPW + 2);
    chk("R2", "first word data", int'(rd_data), int'(pat(ra(5, 3))));
    chk("R2", "RAM reads in burst", mem_rd_cnt - c0, 4);
    dma_write(ra(5, 2), 16'hBEEF);
    dma_write(ra(5, 1), 16'hCAFE);
    c0 = mem_rd_cnt;
    host_read(ma(5, 2), 4);
    chk("R3", "hit latency", rd_lat, 1);
    chk("R3", "snapshot value idx2", int'(rd_data), int'(pat(ra(5, 2))));
    host_read(ma(5, 1), 0);
    chk("R3", "snapshot value idx1", int'(rd_data), int'(pat(ra(5, 1))));
    host_read(ma(5, 0), 0);
    chk("R3", "snapshot value idx0", int'(rd_data), int'(pat(ra(5, 0))));
    chk("R3", "no RAM reads on hits", mem_rd_cnt - c0, 0);
    host_read(ma(5, 1), 0);
    chk("R4", "re-burst latency after idx0", rd_lat, 2 * CPW + 2);
    chk("R4", "fresh RAM value", int'(rd_data), 16'hCAFE);
    host_read(ma(5, 0), 0);
  endtask

  task automatic t_dma_during;
    int c0;
    fork
      host_read(ma(9, 7), 0);
      begin
        repeat (120) @(negedge clk);
        dma_busy = 1'b1;
        dma_write(ra(12, 3), 16'h1111);
      end
    join
    chk("R5", "burst latency unchanged", rd_lat, 8 * CPW + 2);
    chk("R5", "burst data", int'(rd_data), int'(pat(ra(9, 7))));
    c0 = mem_rd_cnt;
    host_read(ma(9, 6), 0);
    chk("R5", "hit served while DMA busy", rd_lat, 1);
    chk("R5", "hit data while DMA busy", int'(rd_data), int'(pat(ra(9, 6))));
    fork
      host_read(ma(0, 4), 0);
      begin
        repeat (40) @(negedge clk);
        chk("R5", "no RAM access while DMA busy", mem_rd_cnt - c0, 0);
        chk("R5", "direct read held off", int'(rsp_valid), 0);
        dma_busy = 1'b0;
      end
    join
    chk("R5", "direct read data after DMA", int'(rd_data), int'(pat(ra(0, 4))));
    host_read(ma(9, 0), 0);
    chk("R5", "snapshot close", int'(rd_data), int'(pat(ra(9, 0))));
  endtask

  task automatic t_dma_before;
    int c0;
    dma_busy = 1'b1;
    c0 = mem_rd_cnt;
    fork
      host_read(ma(14, 2), 0);
      begin
        repeat (80) @(negedge clk);
        chk("R6", "no RAM access before DMA ends", mem_rd_cnt - c0, 0);
        chk("R6", "host still waiting", int'(rsp_valid), 0);
        dma_busy = 1'b0;
      end
    join
    chk("R6", "latency covers wait plus burst", int'(rd_lat >= 80 + 3 * CPW), 1);
    chk("R6", "data", int'(rd_data), int'(pat(ra(14, 2))));
    chk("R6", "burst reads after DMA", mem_rd_cnt - c0, 3);
    host_read(ma(14, 0), 0);
  endtask

  task automatic t_unbuf;
    int c0;
    c0 = mem_rd_cnt;
    host_read(ma(0, 5), 0);
    chk("R7", "sa0 latency", rd_lat, 3);
    chk("R7", "sa0 data", int'(rd_data), int'(pat(ra(0, 5))));
    host_read(ma(31, 2), 0);
    chk("R7", "sa31 latency", rd_lat, 3);
    dma_write(ra(31, 2), 16'h7777);
    host_read(ma(31, 2), 0);
    chk("R7", "sa31 current data", int'(rd_data), 16'h7777);
    chk("R7", "one RAM read each", mem_rd_cnt - c0, 3);
  endtask

  task automatic t_config;
    int c0;
    host_write(11'h402, 16'h0);
    chk("R8", "402h wr_buf_en", int'(wr_buf_en), 0);
    c0 = mem_rd_cnt;
    host_read(ma(6, 3), 0);
    chk("R9", "read disabled: direct latency", rd_lat, 3);
    chk("R9", "read disabled: one RAM read", mem_rd_cnt - c0, 1);
    host_write(11'h403, 16'h0);
    chk("R8", "403h wr_buf_en", int'(wr_buf_en), 1);
    host_read(ma(6, 3), 0);
    chk("R8", "403h read still direct", rd_lat, 3);
    host_write(11'h404, 16'h0);
    chk("R8", "404h wr_buf_en", int'(wr_buf_en), 0);
    host_read(ma(6, 3), 0);
    chk("R8", "404h read buffered", rd_lat, 4 * CPW + 2);
    host_write(11'h403, 16'h0);
    host_write(11'h405, 16'h0);
    chk("R8", "405h wr_buf_en", int'(wr_buf_en), 1);
    host_read(ma(6, 2), 0);
    chk("R9", "disable dropped snapshot", rd_lat, 3 * CPW + 2);
    host_write(11'h406, 16'h0);
    host_write(11'h401, 16'h0);
    chk("R8", "other offsets ignored: wr_buf_en", int'(wr_buf_en), 1);
    host_read(ma(6, 1), 0);
    chk("R8", "other offsets ignored: still hit", rd_lat, 1);
    host_read(ma(6, 0), 0);
  endtask

  task automatic t_write;
    dma_busy = 1'b1;
    host_write(ma(7, 4), 16'h1234);
    repeat (20) @(negedge clk);
    chk("R10", "write held off by DMA", int'(ram[ra(7, 4)]), int'(pat(ra(7, 4))));
    chk("R10", "host waits", int'(req_ready), 0);
    dma_busy = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "write landed", int'(ram[ra(7, 4)]), 16'h1234);
    chk("R10", "no response for write", int'(rsp_valid), 0);
    host_read(ma(7, 5), 0);
    host_write(ma(7, 4), 16'h5678);
    repeat (3) @(negedge clk);
    host_read(ma(7, 4), 0);
    chk("R10", "snapshot untouched by write", int'(rd_data), 16'h1234);
    host_read(ma(7, 0), 0);
  endtask

  task automatic t_miss;
    host_read(ma(20, 3), 0);
    host_read(ma(21, 2), 0);
    chk("R12", "other subaddress re-bursts", rd_lat, 3 * CPW + 2);
    chk("R12", "data", int'(rd_data), int'(pat(ra(21, 2))));
    host_read(ma(21, 4), 0);
    chk("R12", "index above top re-bursts", rd_lat, 5 * CPW + 2);
    host_read(ma(21, 0), 0);
    chk("R12", "new snapshot hit", rd_lat, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ram_init = 1'b1;
    repeat (2) @(negedge clk);
    ram_init = 1'b0;
    repeat (2) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_burst;
    t_dma_during;
    t_dma_before;
    t_unbuf;
    t_config;
    t_write;
    t_miss;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule